// File: doc/BRIEF.md
# Debug System Bus Access Master

This block gives an external debugger a way to read and write memory or devices on the system bus while the hart keeps running. The debugger reaches it through a small register bus. One control/status word selects the access width, the trigger modes and the stepping mode. It also reports a busy flag and a sticky error code. Address words and data words hold the operands of an access.

Each access is a single beat on a valid/ready request port, followed by a response. Accesses are started by register side effects. Writing the low data word starts a write. Writing the low address word starts a read when read-on-address mode is on. Reading the low data word starts the next read when read-on-data mode is on. With stepping on, the address moves forward by the access size after each successful access, so a debugger can stream through memory with one register access per word. Misaligned or unsupported accesses, collisions with an access still in flight, bus error responses and silent slaves are caught and reported in the error code.

Top module: `dbg_sysbus_master`

## Requirements
- R1: After reset the address, both data words and the error code are 0, busy is 0, and every writable control field is 0. The control word reads back capability 0x0F in bits [4:0] (8, 16, 32 and 64 bit supported, 128 bit not) and ADDR_W in bits [11:5].
- R2: Register offsets are fixed. 0x38 is the control word, 0x39/0x3A/0x3B are address bits [31:0]/[63:32]/[95:64], and 0x3C/0x3D are data bits [31:0]/[63:32]. 0x3E, 0x3F and address bits at or above ADDR_W read as 0.
- R3: Control bits [20:18] select the width: code 0=8, 1=16, 2=32, 3=64, 4=128 bits. That code is driven on mem_req_size. Only codes whose capability bit is set are issued.
- R4: A write to offset 0x3C updates data bits [31:0] and starts a bus write at the current address. The write data is {data[63:32], data[31:0]} with all bits above the width forced to 0.
- R5: With control bit 21 set, writing offset 0x39 updates the address and starts a bus read at the new address.
- R6: Read data is taken right-justified from mem_rsp_rdata. Bits above the width are zeroed into data[31:0]. Data[63:32] is loaded only by 64-bit reads. The data lands on the same edge that clears busy (control bit 15).
- R7: With control bit 16 set, reading offset 0x3C returns the current data and then starts a bus read at the current address.
- R8: With control bit 17 set, each successful access adds its size in bytes (1, 2, 4 or 8) to the address.
- R9: While busy, any write to the address or data words, and any read-on-data trigger, is dropped and sets the error code (control bits [14:12]) to 4.
- R10: An access whose address is not a multiple of its size, or whose width code is unsupported (4 to 7), is not issued and sets the error code to 3.
- R11: An access not completed within TMO_CYC cycles of its start sets the error code to 1 and clears busy.
- R12: A response with mem_rsp_err set ends the access with error code 2 and no data or address update.
- R13: The error code stays set until software writes 1s to control bits [14:12]; each 1 clears its bit. A newly detected error takes priority over a clear in the same cycle.
- R14: A request stays valid, with stable address, write flag and data, until mem_req_ready accepts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rb_valid | input | 1 | Register access strobe, one cycle per access |
| rb_write | input | 1 | 1 = register write, 0 = register read |
| rb_addr | input | 7 | Register offset |
| rb_wdata | input | 32 | Register write data |
| rb_rdata | output | 32 | Register read data, combinational from rb_addr |
| mem_req_valid | output | 1 | Bus request valid |
| mem_req_ready | input | 1 | Bus request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Byte address |
| mem_req_size | output | 3 | Width code |
| mem_req_wdata | output | 64 | Right-justified write data |
| mem_rsp_valid | input | 1 | Response valid, at least one cycle after acceptance |
| mem_rsp_err | input | 1 | Response carries a bus error |
| mem_rsp_rdata | input | 64 | Right-justified read data |

## Verification
A triggering register access at one edge raises the request in the next cycle. With a ready slave the handshake happens at the following edge, and a response one cycle after that completes the access. Read data, the stepped address and the cleared busy flag can therefore be read back three cycles after the trigger. The bench waits six cycles before reading them. Alignment and width errors show in the control word on the cycle after the access. A busy collision shows at once. The timeout case is sampled only after TMO_CYC plus a margin. A scoreboard compares every request at its handshake against an expected item pushed before the trigger, so an extra, missing or altered request is reported.

// File: rtl/dsb_pkg.sv
package dsb_pkg;

   localparam int unsigned BUS_DW = 64;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_REQ  = 2'd1,
      SQ_WAIT = 2'd2
   } sq_state_e;

   // error codes reported in control bits [14:12]
   localparam logic [2:0] ERR_NONE    = 3'd0;
   localparam logic [2:0] ERR_TIMEOUT = 3'd1;
   localparam logic [2:0] ERR_BADADDR = 3'd2;
   localparam logic [2:0] ERR_OTHER   = 3'd3;
   localparam logic [2:0] ERR_BUSY    = 3'd4;

   // register offsets seen by the debugger
   localparam logic [6:0] OFF_CTL = 7'h38;
   localparam logic [6:0] OFF_A0  = 7'h39;
   localparam logic [6:0] OFF_A1  = 7'h3A;
   localparam logic [6:0] OFF_A2  = 7'h3B;
   localparam logic [6:0] OFF_D0  = 7'h3C;
   localparam logic [6:0] OFF_D1  = 7'h3D;

   function automatic logic [4:0] size_bytes(input logic [2:0] code);
      case (code)
         3'd0:    return 5'd1;
         3'd1:    return 5'd2;
         3'd2:    return 5'd4;
         3'd3:    return 5'd8;
         3'd4:    return 5'd16;
         default: return 5'd0;
      endcase
   endfunction

   function automatic logic [BUS_DW-1:0] size_mask(input logic [2:0] code);
      case (code)
         3'd0:    return 64'h0000_0000_0000_00FF;
         3'd1:    return 64'h0000_0000_0000_FFFF;
         3'd2:    return 64'h0000_0000_FFFF_FFFF;
         default: return {BUS_DW{1'b1}};
      endcase
   endfunction

endpackage

// File: rtl/dsb_size_check.sv
module dsb_size_check
   import dsb_pkg::*;
#(
   parameter logic [4:0] CAP_MASK = 5'b01111
)(
   input  logic [2:0] width_code,
   input  logic [3:0] addr_lo,
   output logic       width_ok,
   output logic       aligned
);

   localparam int unsigned NCODES = 8;

   logic [NCODES-1:0] cap_vec;
   logic [4:0]        lane_mask;

   // one entry per width code; codes beyond the capability field are never legal
   for (genvar i = 0; i < NCODES; i++) begin : g_cap
      if (i < 5) begin : g_known
         assign cap_vec[i] = CAP_MASK[i];
      end else begin : g_reserved
         assign cap_vec[i] = 1'b0;
      end
   end

   always_comb begin
      lane_mask = size_bytes(width_code) - 5'd1;
      width_ok  = cap_vec[width_code];
      aligned   = (({1'b0, addr_lo} & lane_mask) == 5'd0);
   end

endmodule

// File: rtl/dsb_bus_seq.sv
module dsb_bus_seq
   import dsb_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned TMO_CYC = 64
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                start_we,
   input  logic [ADDR_W-1:0]   start_addr,
   input  logic [2:0]          start_size,
   input  logic [BUS_DW-1:0]   start_wdata,
   output logic                req_valid,
   input  logic                req_ready,
   output logic                req_write,
   output logic [ADDR_W-1:0]   req_addr,
   output logic [2:0]          req_size,
   output logic [BUS_DW-1:0]   req_wdata,
   input  logic                rsp_valid,
   input  logic                rsp_err,
   output logic                busy,
   output logic                fin_ok,
   output logic                fin_buserr,
   output logic                fin_tmo
);

   localparam int unsigned      CNT_W    = $clog2(TMO_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYC - 1);

   sq_state_e        state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             rsp_now;

   always_comb begin
      rsp_now    = (state_q == SQ_WAIT) && rsp_valid;
      busy       = (state_q != SQ_IDLE);
      req_valid  = (state_q == SQ_REQ);
      fin_ok     = rsp_now && !rsp_err;
      fin_buserr = rsp_now && rsp_err;
      fin_tmo    = busy && (cnt_q == CNT_LAST) && !rsp_now;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SQ_IDLE;
         cnt_q     <= '0;
         req_write <= 1'b0;
         req_addr  <= '0;
         req_size  <= '0;
         req_wdata <= '0;
      end else begin
         case (state_q)
            SQ_IDLE: begin
               if (start) begin
                  state_q   <= SQ_REQ;
                  cnt_q     <= '0;
                  req_write <= start_we;
                  req_addr  <= start_addr;
                  req_size  <= start_size;
                  req_wdata <= start_wdata;
               end
            end
            SQ_REQ: begin
               cnt_q <= cnt_q + 1'b1;
               if (fin_tmo)        state_q <= SQ_IDLE;
               else if (req_ready) state_q <= SQ_WAIT;
            end
            SQ_WAIT: begin
               cnt_q <= cnt_q + 1'b1;
               if (rsp_now || fin_tmo) state_q <= SQ_IDLE;
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   // R14: an unaccepted request is held unchanged
   assert_req_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready && !fin_tmo) |=>
         (req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_wdata)));

   // R11: a timeout always returns the sequencer to idle
   assert_tmo_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
      fin_tmo |=> !busy);

endmodule

// File: rtl/dbg_sysbus_master.sv
module dbg_sysbus_master
   import dsb_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter logic [4:0]  CAP_MASK = 5'b01111,
   parameter int unsigned TMO_CYC  = 64
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rb_valid,
   input  logic                rb_write,
   input  logic [6:0]          rb_addr,
   input  logic [31:0]         rb_wdata,
   output logic [31:0]         rb_rdata,
   output logic                mem_req_valid,
   input  logic                mem_req_ready,
   output logic                mem_req_write,
   output logic [ADDR_W-1:0]   mem_req_addr,
   output logic [2:0]          mem_req_size,
   output logic [63:0]         mem_req_wdata,
   input  logic                mem_rsp_valid,
   input  logic                mem_rsp_err,
   input  logic [63:0]         mem_rsp_rdata
);

   localparam int unsigned XW       = 96;
   localparam logic [6:0]  AW_FIELD = 7'(ADDR_W);

   if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_aw
      $error("dbg_sysbus_master: ADDR_W must lie in 8..64");
   end
   if (CAP_MASK[4]) begin : g_bad_cap
      $error("dbg_sysbus_master: data path is 64 bits, 128-bit capability not allowed");
   end
   if (TMO_CYC < 2) begin : g_bad_tmo
      $error("dbg_sysbus_master: TMO_CYC must be at least 2");
   end

   logic [ADDR_W-1:0] addr_q;
   logic [31:0]       data0_q, data1_q;
   logic [2:0]        err_q, width_q;
   logic              auto_rd_q, auto_inc_q, rd_on_addr_q;

   logic wr, rd, wr_ctl, wr_a0, wr_a1, wr_a2, wr_d0, wr_d1, rd_d0;
   logic busy, fin_ok, fin_buserr, fin_tmo;
   logic trig, busy_viol, do_start, bad_issue;
   logic width_ok, aligned;
   logic [XW-1:0]     addr_ext, addr_wr_ext;
   logic [ADDR_W-1:0] addr_cand, step;
   logic [31:0]       d0_cand;
   logic [63:0]       start_wdata, rd_masked;
   logic              unused_hi;

   always_comb begin
      wr     = rb_valid && rb_write;
      rd     = rb_valid && !rb_write;
      wr_ctl = wr && (rb_addr == OFF_CTL);
      wr_a0  = wr && (rb_addr == OFF_A0);
      wr_a1  = wr && (rb_addr == OFF_A1);
      wr_a2  = wr && (rb_addr == OFF_A2);
      wr_d0  = wr && (rb_addr == OFF_D0);
      wr_d1  = wr && (rb_addr == OFF_D1);
      rd_d0  = rd && (rb_addr == OFF_D0);

      addr_ext    = XW'(addr_q);
      addr_wr_ext = addr_ext;
      if (wr_a0) addr_wr_ext[31:0]  = rb_wdata;
      if (wr_a1) addr_wr_ext[63:32] = rb_wdata;
      if (wr_a2) addr_wr_ext[95:64] = rb_wdata;
      addr_cand = addr_wr_ext[ADDR_W-1:0];
      d0_cand   = wr_d0 ? rb_wdata : data0_q;

      trig      = (wr_a0 && rd_on_addr_q) || wr_d0 || (rd_d0 && auto_rd_q);
      busy_viol = busy && (wr_a0 || wr_a1 || wr_a2 || wr_d0 || wr_d1 || (rd_d0 && auto_rd_q));
      do_start  = trig && !busy && width_ok && aligned;
      bad_issue = trig && !busy && !(width_ok && aligned);

      start_wdata = {data1_q, d0_cand} & size_mask(width_q);
      rd_masked   = mem_rsp_rdata & size_mask(mem_req_size);
      step        = ADDR_W'(size_bytes(mem_req_size));
      unused_hi   = ^addr_wr_ext[XW-1:ADDR_W];
   end

   dsb_size_check #(.CAP_MASK(CAP_MASK)) u_size (
      .width_code (width_q),
      .addr_lo    (addr_cand[3:0]),
      .width_ok   (width_ok),
      .aligned    (aligned)
   );

   dsb_bus_seq #(.ADDR_W(ADDR_W), .TMO_CYC(TMO_CYC)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (do_start),
      .start_we    (wr_d0),
      .start_addr  (addr_cand),
      .start_size  (width_q),
      .start_wdata (start_wdata),
      .req_valid   (mem_req_valid),
      .req_ready   (mem_req_ready),
      .req_write   (mem_req_write),
      .req_addr    (mem_req_addr),
      .req_size    (mem_req_size),
      .req_wdata   (mem_req_wdata),
      .rsp_valid   (mem_rsp_valid),
      .rsp_err     (mem_rsp_err),
      .busy        (busy),
      .fin_ok      (fin_ok),
      .fin_buserr  (fin_buserr),
      .fin_tmo     (fin_tmo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q       <= '0;
         data0_q      <= '0;
         data1_q      <= '0;
         err_q        <= ERR_NONE;
         width_q      <= '0;
         auto_rd_q    <= 1'b0;
         auto_inc_q   <= 1'b0;
         rd_on_addr_q <= 1'b0;
      end else begin
         if (wr_ctl) begin
            rd_on_addr_q <= rb_wdata[21];
            width_q      <= rb_wdata[20:18];
            auto_inc_q   <= rb_wdata[17];
            auto_rd_q    <= rb_wdata[16];
         end
         if (!busy) begin
            addr_q  <= addr_cand;
            data0_q <= d0_cand;
            if (wr_d1) data1_q <= rb_wdata;
         end else if (fin_ok) begin
            if (!mem_req_write) begin
               data0_q <= rd_masked[31:0];
               if (mem_req_size == 3'd3) data1_q <= rd_masked[63:32];
            end
            if (auto_inc_q) addr_q <= addr_q + step;
         end
         if (fin_tmo)         err_q <= ERR_TIMEOUT;
         else if (fin_buserr) err_q <= ERR_BADADDR;
         else if (busy_viol)  err_q <= ERR_BUSY;
         else if (bad_issue)  err_q <= ERR_OTHER;
         else if (wr_ctl)     err_q <= err_q & ~rb_wdata[14:12];
      end
   end

   always_comb begin
      case (rb_addr)
         OFF_CTL: rb_rdata = {10'd0, rd_on_addr_q, width_q, auto_inc_q, auto_rd_q,
                              busy, err_q, AW_FIELD, CAP_MASK};
         OFF_A0:  rb_rdata = addr_ext[31:0];
         OFF_A1:  rb_rdata = addr_ext[63:32];
         OFF_A2:  rb_rdata = addr_ext[95:64];
         OFF_D0:  rb_rdata = data0_q;
         OFF_D1:  rb_rdata = data1_q;
         default: rb_rdata = 32'd0;
      endcase
   end

   // R13: only defined codes ever appear
   assert_err_code_R13: assert property (@(posedge clk) disable iff (!rst_n)
      err_q <= ERR_BUSY);

   // R3: only advertised widths reach the bus
   assert_size_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> ((mem_req_size <= 3'd4) && CAP_MASK[mem_req_size]));

   // R10: issued addresses are naturally aligned
   assert_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> ((mem_req_addr[3:0] & (size_bytes(mem_req_size) - 5'd1)) == 4'd0));

   // R10: a rejected access raises no request
   assert_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bad_issue |=> (!mem_req_valid && err_q == ERR_OTHER));

   // R9: a collision with an access in flight reports busy error
   assert_busy_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_viol && !fin_tmo && !fin_buserr) |=> (err_q == ERR_BUSY));

endmodule

// File: tb/test_dbg_sysbus_master.sv
module test_dbg_sysbus_master;

   localparam int unsigned TMO = 40;

   typedef struct {
      logic        we;
      logic [31:0] addr;
      logic [2:0]  size;
      logic [63:0] wdata;
   } exp_t;

   logic        clk, rst_n;
   logic        rb_valid, rb_write;
   logic [6:0]  rb_addr;
   logic [31:0] rb_wdata, rb_rdata;
   logic        mem_req_valid, mem_req_ready, mem_req_write;
   logic [31:0] mem_req_addr;
   logic [2:0]  mem_req_size;
   logic [63:0] mem_req_wdata;
   logic        mem_rsp_valid, mem_rsp_err;
   logic [63:0] mem_rsp_rdata;

   int   n_chk = 0;
   int   n_fail = 0;
   exp_t exp_q[$];
   bit   ready_block = 0, silent = 0, errm = 0;

   dbg_sysbus_master #(.ADDR_W(32), .CAP_MASK(5'b01111), .TMO_CYC(TMO)) i_dbg_sysbus_master (
      .clk(clk), .rst_n(rst_n),
      .rb_valid(rb_valid), .rb_write(rb_write), .rb_addr(rb_addr),
      .rb_wdata(rb_wdata), .rb_rdata(rb_rdata),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
      .mem_req_size(mem_req_size), .mem_req_wdata(mem_req_wdata),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
      .mem_rsp_rdata(mem_rsp_rdata)
   );

   initial begin
      clk = 0;
      forever #5 clk = ~clk;
   end

   function automatic logic [63:0] pat(input logic [31:0] a);
      return {a ^ 32'hC3C3_1234, a + 32'h1111_0000};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      rb_valid = 1; rb_write = 1; rb_addr = a; rb_wdata = d;
      @(negedge clk);
      rb_valid = 0; rb_write = 0;
   endtask

   task automatic reg_rd(input logic [6:0] a, output logic [31:0] d);
      @(negedge clk);
      rb_valid = 1; rb_write = 0; rb_addr = a;
      #1 d = rb_rdata;
      @(negedge clk);
      rb_valid = 0;
   endtask

   task automatic expect_req(input logic we, input logic [31:0] a, input logic [2:0] s, input logic [63:0] wd);
      exp_t e;
      e.we = we; e.addr = a; e.size = s; e.wdata = wd;
      exp_q.push_back(e);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // memory model and scoreboard monitor
   initial begin
      bit          hs_pend;
      logic [31:0] hs_addr;
      hs_pend = 0; hs_addr = 0;
      mem_req_ready = 1; mem_rsp_valid = 0; mem_rsp_err = 0; mem_rsp_rdata = '0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 0; mem_rsp_err = 0;
         if (hs_pend && !silent) begin
            mem_rsp_valid = 1; mem_rsp_err = errm; mem_rsp_rdata = pat(hs_addr);
         end
         hs_pend = 0;
         mem_req_ready = !ready_block;
         if (rst_n && mem_req_valid && mem_req_ready) begin
            hs_pend = 1; hs_addr = mem_req_addr;
            if (exp_q.size() == 0) begin
               chk(0, "R4/R5/R7 unexpected request", {31'd0, mem_req_write, mem_req_addr}, 64'd0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(mem_req_write == e.we, "R4/R5 request direction", {63'd0, mem_req_write}, {63'd0, e.we});
               chk(mem_req_addr == e.addr, "R8/R14 request address", {32'd0, mem_req_addr}, {32'd0, e.addr});
               chk(mem_req_size == e.size, "R3 request size", {61'd0, mem_req_size}, {61'd0, e.size});
               if (e.we)
                  chk(mem_req_wdata == e.wdata, "R4 write data", mem_req_wdata, e.wdata);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [63:0] p;
      rst_n = 0; rb_valid = 0; rb_write = 0; rb_addr = 0; rb_wdata = 0;
      idle(3);
      rst_n = 1;
      idle(2);

      // R1 / R2: reset state and map
      reg_rd(7'h38, v); chk(v == 32'h0000_040F, "R1 control reset", {32'd0, v}, 64'h40F);
      reg_rd(7'h39, v); chk(v == 0, "R1 address reset", {32'd0, v}, 0);
      reg_rd(7'h3C, v); chk(v == 0, "R1 data reset", {32'd0, v}, 0);
      reg_rd(7'h3B, v); chk(v == 0, "R2 upper address word reads 0", {32'd0, v}, 0);
      reg_rd(7'h3F, v); chk(v == 0, "R2 unused data word reads 0", {32'd0, v}, 0);

      // R4: 32-bit write masks data[63:32]
      reg_wr(7'h38, 32'h0008_0000);
      reg_wr(7'h39, 32'h100);
      reg_wr(7'h3D, 32'h0000_DEAD);
      expect_req(1, 32'h100, 3'd2, 64'h0000_0000_CAFE_BABE);
      reg_wr(7'h3C, 32'hCAFE_BABE);
      idle(6);
      reg_rd(7'h38, v); chk(v[15:12] == 0, "R4 write completes without error", {60'd0, v[15:12]}, 0);

      // R3 / R4: 8-bit write at odd address
      reg_wr(7'h38, 32'h0000_0000);
      reg_wr(7'h39, 32'h103);
      expect_req(1, 32'h103, 3'd0, 64'hBE);
      reg_wr(7'h3C, 32'h1234_56BE);
      idle(6);

      // R3 / R4: 64-bit write uses both words
      reg_wr(7'h38, 32'h000C_0000);
      reg_wr(7'h39, 32'h800);
      reg_wr(7'h3D, 32'h0BAD_F00D);
      expect_req(1, 32'h800, 3'd3, 64'h0BAD_F00D_600D_CAFE);
      reg_wr(7'h3C, 32'h600D_CAFE);
      idle(6);
      reg_wr(7'h3D, 32'h0000_DEAD);

      // R5 / R6: read on address write, 32-bit
      reg_wr(7'h38, 32'h0028_0000);
      expect_req(0, 32'h200, 3'd2, 0);
      reg_wr(7'h39, 32'h200);
      idle(6);
      p = pat(32'h200);
      reg_rd(7'h3C, v); chk(v == p[31:0], "R5 read on address write data", {32'd0, v}, {32'd0, p[31:0]});

      // R6: 16-bit read zero-extends, leaves data[63:32]
      reg_wr(7'h38, 32'h0024_0000);
      expect_req(0, 32'h202, 3'd1, 0);
      reg_wr(7'h39, 32'h202);
      idle(6);
      p = pat(32'h202);
      reg_rd(7'h3C, v); chk(v == {16'd0, p[15:0]}, "R6 16-bit read right-justified", {32'd0, v}, {48'd0, p[15:0]});
      reg_rd(7'h3D, v); chk(v == 32'h0000_DEAD, "R6 narrow read keeps upper word", {32'd0, v}, 64'hDEAD);

      // R6: 64-bit read fills both words
      reg_wr(7'h38, 32'h002C_0000);
      expect_req(0, 32'h208, 3'd3, 0);
      reg_wr(7'h39, 32'h208);
      idle(6);
      p = pat(32'h208);
      reg_rd(7'h3C, v); chk(v == p[31:0], "R6 64-bit read low word", {32'd0, v}, {32'd0, p[31:0]});
      reg_rd(7'h3D, v); chk(v == p[63:32], "R6 64-bit read high word", {32'd0, v}, {32'd0, p[63:32]});

      // R7 / R8: read on data read with stepping
      reg_wr(7'h38, 32'h002B_0000);
      expect_req(0, 32'h300, 3'd2, 0);
      reg_wr(7'h39, 32'h300);
      idle(6);
      expect_req(0, 32'h304, 3'd2, 0);
      p = pat(32'h300);
      reg_rd(7'h3C, v); chk(v == p[31:0], "R7 data read returns current value", {32'd0, v}, {32'd0, p[31:0]});
      idle(6);
      reg_rd(7'h39, v); chk(v == 32'h308, "R8 address stepped by 4 twice", {32'd0, v}, 64'h308);
      expect_req(0, 32'h308, 3'd2, 0);
      p = pat(32'h304);
      reg_rd(7'h3C, v); chk(v == p[31:0], "R7 second streamed read", {32'd0, v}, {32'd0, p[31:0]});
      idle(6);
      reg_rd(7'h39, v); chk(v == 32'h30C, "R8 address after streamed read", {32'd0, v}, 64'h30C);
      reg_wr(7'h38, 32'h0000_0000);

      // R8: stepping by 2 on 16-bit writes
      reg_wr(7'h38, 32'h0006_0000);
      reg_wr(7'h39, 32'h400);
      expect_req(1, 32'h400, 3'd1, 64'hAAAA);
      reg_wr(7'h3C, 32'h1234_AAAA);
      idle(6);
      expect_req(1, 32'h402, 3'd1, 64'hBBBB);
      reg_wr(7'h3C, 32'h5555_BBBB);
      idle(6);
      reg_rd(7'h39, v); chk(v == 32'h404, "R8 address stepped by 2", {32'd0, v}, 64'h404);

      // R9 / R14 / R13: collision while stalled
      reg_wr(7'h38, 32'h0008_0000);
      reg_wr(7'h39, 32'h500);
      ready_block = 1;
      expect_req(1, 32'h500, 3'd2, 64'h1111_1111);
      reg_wr(7'h3C, 32'h1111_1111);
      reg_wr(7'h3C, 32'h2222_2222);
      reg_rd(7'h38, v);
      chk(v[15:12] == 4'hC, "R9 busy set and error code 4", {60'd0, v[15:12]}, 64'hC);
      ready_block = 0;
      idle(6);
      reg_rd(7'h3C, v); chk(v == 32'h1111_1111, "R9 colliding write dropped", {32'd0, v}, 64'h1111_1111);
      reg_rd(7'h38, v); chk(v[14:12] == 3'd4, "R13 error sticky after success", {61'd0, v[14:12]}, 64'd4);
      reg_wr(7'h38, 32'h0008_7000);
      reg_rd(7'h38, v); chk(v[14:12] == 3'd0, "R13 write 1s clears error", {61'd0, v[14:12]}, 0);

      // R10: misaligned and unsupported widths
      reg_wr(7'h39, 32'h602);
      reg_wr(7'h3C, 32'h3333_3333);
      idle(3);
      reg_rd(7'h38, v); chk(v[15:12] == 4'h3, "R10 misaligned rejected", {60'd0, v[15:12]}, 64'h3);
      reg_wr(7'h38, 32'h0010_7000);
      reg_wr(7'h39, 32'h700);
      reg_wr(7'h3C, 32'h4444_4444);
      idle(3);
      reg_rd(7'h38, v); chk(v[15:12] == 4'h3, "R10 128-bit width rejected", {60'd0, v[15:12]}, 64'h3);
      reg_wr(7'h38, 32'h0008_7000);

      // R11: timeout
      silent = 1;
      reg_wr(7'h39, 32'h900);
      expect_req(1, 32'h900, 3'd2, 64'h77);
      reg_wr(7'h3C, 32'h77);
      idle(4);
      reg_rd(7'h38, v); chk(v[15] == 1'b1, "R11 busy while waiting", {63'd0, v[15]}, 1);
      idle(TMO + 4);
      reg_rd(7'h38, v); chk(v[15:12] == 4'h1, "R11 timeout code and busy clear", {60'd0, v[15:12]}, 64'h1);
      silent = 0;
      reg_wr(7'h38, 32'h0008_7000);

      // R12: bus error response
      errm = 1;
      reg_wr(7'h39, 32'hA00);
      expect_req(1, 32'hA00, 3'd2, 64'h88);
      reg_wr(7'h3C, 32'h88);
      idle(6);
      reg_rd(7'h38, v); chk(v[15:12] == 4'h2, "R12 bus error code", {60'd0, v[15:12]}, 64'h2);
      errm = 0;
      reg_wr(7'h38, 32'h0000_7000);
      reg_rd(7'h38, v); chk(v == 32'h0000_040F, "R13 control clean after clear", {32'd0, v}, 64'h40F);

      idle(4);
      chk(exp_q.size() == 0, "R4/R5/R7 all expected requests seen", exp_q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule